// File: doc/BRIEF.md
# Dual-Master Shared RAM Bank Switch

This block places two small RAM banks between two independent processor buses, called master A and master B. A one-byte control register, written through a dedicated configuration port, sets which master owns each bank. A bank belongs to exactly one master at any time. A producer can fill a bank and then hand it to the other master by writing the register, with no data copy.

Each master reaches the banks it owns through a word-addressed window that repeats across its whole range. With one bank the window repeats every bank size. With two banks it repeats every two bank sizes, and the lower half maps to bank 0. A master that owns no bank still has its accesses complete in one cycle. Its reads return zero and its writes are dropped. The current allocation is always visible on a status output.

Top module: `srb_top`

## Requirements
- R1: After reset the allocation is 0, so master A owns both banks, and both read data outputs are zero.
- R2: A bank is reachable by only one master at a time. Data written into a bank by one master is read back unchanged by the other master once the bank is handed over.
- R3: Allocation encoding: 0 gives banks 0 and 1 to A. 1 gives bank 0 to A and bank 1 to B. 2 gives bank 1 to A and bank 0 to B. 3 gives both banks to B.
- R4: A configuration write loads bits [1:0] of the byte into the allocation, and bits [7:2] are ignored. The new allocation applies from the clock edge that follows the write. An access issued in the same cycle as the write uses the old allocation.
- R5: A master owning one bank reaches word offset (address mod BANK_WORDS) of that bank, and its upper address bits are ignored.
- R6: A master owning both banks uses address bit BANK_AW to pick the bank, with 0 selecting bank 0. The mapping repeats every 2*BANK_WORDS words.
- R7: A master owning no bank reads zero, and its writes leave both banks unchanged.
- R8: Read data appears on the cycle after the request. In a cycle that follows no read request, the read data output is zero.
- R9: The status output alloc_o always shows the allocation currently in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_wdata | input | 8 | Configuration byte; bits [1:0] hold the allocation |
| alloc_o | output | 2 | Current allocation |
| a_req | input | 1 | Master A access request |
| a_we | input | 1 | Master A write (1) or read (0) |
| a_addr | input | WIN_AW | Master A word address within the window |
| a_wdata | input | DATA_W | Master A write data |
| a_rdata | output | DATA_W | Master A read data, one cycle after the request |
| b_req | input | 1 | Master B access request |
| b_we | input | 1 | Master B write (1) or read (0) |
| b_addr | input | WIN_AW | Master B word address within the window |
| b_wdata | input | DATA_W | Master B write data |
| b_rdata | output | DATA_W | Master B read data, one cycle after the request |

## Verification
For each of the four allocations, both masters sweep every window address. They first read back the contents left by the previous allocation, then write an address-tagged value, then read again. The first read phase shows whether a handover keeps the data. Because writes to aliased addresses overwrite one another, the second phase separates 16-word mirroring from 32-word mirroring and shows which half maps to which bank. Reads by a master that owns no bank must return zero, and the data left in the banks must show that its writes were dropped. Further targeted cycles cover a configuration write issued together with an access, a configuration byte with its upper bits set, and an idle cycle after a read.

// File: rtl/srb_pkg.sv
package srb_pkg;

    typedef enum logic [1:0] {
        ALLOC_ALL_A = 2'd0,
        ALLOC_A0_B1 = 2'd1,
        ALLOC_A1_B0 = 2'd2,
        ALLOC_ALL_B = 2'd3
    } alloc_e;

    typedef enum logic {
        MST_A = 1'b0,
        MST_B = 1'b1
    } master_e;

    // Bit i set when the master owns bank i under the given allocation.
    function automatic logic [1:0] owned_mask(alloc_e al, master_e m);
        logic [1:0] a_mask;
        unique case (al)
            ALLOC_ALL_A: a_mask = 2'b11;
            ALLOC_A0_B1: a_mask = 2'b01;
            ALLOC_A1_B0: a_mask = 2'b10;
            default:     a_mask = 2'b00;
        endcase
        return (m == MST_A) ? a_mask : ~a_mask;
    endfunction

endpackage

// File: rtl/srb_map.sv
module srb_map
    import srb_pkg::*;
#(
    parameter int WIN_AW  = 8,
    parameter int BANK_AW = 4,
    parameter master_e MST = MST_A
) (
    input  alloc_e               alloc,
    input  logic                 req,
    input  logic [WIN_AW-1:0]    addr,
    output logic                 hit,
    output logic                 bank_idx,
    output logic [1:0]           bank_en,
    output logic [BANK_AW-1:0]   offset
);
    logic [1:0] mask;

    always_comb begin
        mask   = owned_mask(alloc, MST);
        offset = addr[BANK_AW-1:0];
        unique case (mask)
            2'b11:   bank_idx = addr[BANK_AW];
            2'b10:   bank_idx = 1'b1;
            default: bank_idx = 1'b0;
        endcase
        hit     = req && (mask != 2'b00);
        bank_en = hit ? (bank_idx ? 2'b10 : 2'b01) : 2'b00;
    end

endmodule

// File: rtl/srb_bank.sv
module srb_bank #(
    parameter int DATA_W  = 16,
    parameter int BANK_AW = 4
) (
    input  logic                clk,
    input  logic                en,
    input  logic                we,
    input  logic [BANK_AW-1:0]  addr,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata
);
    localparam int WORDS = 1 << BANK_AW;

    logic [DATA_W-1:0] mem [WORDS];
    logic [DATA_W-1:0] rd_q;

    always_ff @(posedge clk) begin
        if (en && we) mem[addr] <= wdata;
        if (en && !we) rd_q <= mem[addr];
    end

    assign rdata = rd_q;

endmodule

// File: rtl/srb_top.sv
module srb_top
    import srb_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int BANK_AW = 4,
    parameter int WIN_AW  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [7:0]         cfg_wdata,
    output logic [1:0]         alloc_o,
    input  logic               a_req,
    input  logic               a_we,
    input  logic [WIN_AW-1:0]  a_addr,
    input  logic [DATA_W-1:0]  a_wdata,
    output logic [DATA_W-1:0]  a_rdata,
    input  logic               b_req,
    input  logic               b_we,
    input  logic [WIN_AW-1:0]  b_addr,
    input  logic [DATA_W-1:0]  b_wdata,
    output logic [DATA_W-1:0]  b_rdata
);
    localparam int NBANK = 2;

    typedef struct packed {
        alloc_e alloc;
        logic   a_rd;
        logic   a_bank;
        logic   b_rd;
        logic   b_bank;
    } state_t;

    state_t st_d, st_q;

    logic               a_hit, b_hit, a_bidx, b_bidx;
    logic [1:0]         a_ben, b_ben;
    logic [BANK_AW-1:0] a_off, b_off;
    logic [DATA_W-1:0]  bank_rd [NBANK];

    srb_map #(.WIN_AW(WIN_AW), .BANK_AW(BANK_AW), .MST(MST_A)) u_map_a (
        .alloc(st_q.alloc), .req(a_req), .addr(a_addr),
        .hit(a_hit), .bank_idx(a_bidx), .bank_en(a_ben), .offset(a_off)
    );

    srb_map #(.WIN_AW(WIN_AW), .BANK_AW(BANK_AW), .MST(MST_B)) u_map_b (
        .alloc(st_q.alloc), .req(b_req), .addr(b_addr),
        .hit(b_hit), .bank_idx(b_bidx), .bank_en(b_ben), .offset(b_off)
    );

    for (genvar i = 0; i < NBANK; i++) begin : g_bank
        logic               use_b;
        logic               en;
        logic               we;
        logic [BANK_AW-1:0] addr;
        logic [DATA_W-1:0]  wdata;

        assign use_b = b_ben[i];
        assign en    = a_ben[i] | b_ben[i];
        assign we    = use_b ? b_we    : a_we;
        assign addr  = use_b ? b_off   : a_off;
        assign wdata = use_b ? b_wdata : a_wdata;

        srb_bank #(.DATA_W(DATA_W), .BANK_AW(BANK_AW)) u_bank (
            .clk(clk), .en(en), .we(we), .addr(addr),
            .wdata(wdata), .rdata(bank_rd[i])
        );
    end

    always_comb begin
        st_d = st_q;
        if (cfg_we) st_d.alloc = alloc_e'(cfg_wdata[1:0]);
        st_d.a_rd   = a_hit && !a_we;
        st_d.a_bank = a_bidx;
        st_d.b_rd   = b_hit && !b_we;
        st_d.b_bank = b_bidx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{alloc: ALLOC_ALL_A, a_rd: 1'b0, a_bank: 1'b0,
                      b_rd: 1'b0, b_bank: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign alloc_o = st_q.alloc;
    assign a_rdata = st_q.a_rd ? bank_rd[st_q.a_bank] : '0;
    assign b_rdata = st_q.b_rd ? bank_rd[st_q.b_bank] : '0;

    AST_BANK_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (a_ben & b_ben) == 2'b00); // R2
    AST_ALLOC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> alloc_o == $past(cfg_wdata[1:0])); // R4
    AST_ALLOC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(alloc_o)); // R9
    AST_UNOWNED_A_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (a_req && alloc_o == 2'd3) |=> a_rdata == '0); // R7
    AST_UNOWNED_B_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (b_req && alloc_o == 2'd0) |=> b_rdata == '0); // R7
    AST_IDLE_A_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !a_req |=> a_rdata == '0); // R8
    AST_IDLE_B_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !b_req |=> b_rdata == '0); // R8
    AST_ONE_BANK_PER_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(a_ben) && $onehot0(b_ben)); // R3

endmodule

// File: tb/srb_top_tb.sv
`timescale 1ns/1ps
module srb_top_tb;
    localparam int DATA_W  = 16;
    localparam int BANK_AW = 4;
    localparam int WIN_AW  = 8;
    localparam int BW      = 1 << BANK_AW;
    localparam int WIN     = 1 << WIN_AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [1:0] alloc_o;
    logic a_req = 1'b0, a_we = 1'b0, b_req = 1'b0, b_we = 1'b0;
    logic [WIN_AW-1:0] a_addr = '0, b_addr = '0;
    logic [DATA_W-1:0] a_wdata = '0, b_wdata = '0, a_rdata, b_rdata;

    int checks = 0;
    int fails  = 0;
    logic [DATA_W-1:0] model [2][BW];
    bit                valid [2][BW];

    always #2 clk = ~clk;

    srb_top #(.DATA_W(DATA_W), .BANK_AW(BANK_AW), .WIN_AW(WIN_AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .alloc_o(alloc_o),
        .a_req(a_req), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
        .b_req(b_req), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata)
    );

    task automatic check(input string rq, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    // Bank reached by master m (0=A,1=B) at addr under allocation al; -1 when none (R3, R5, R6).
    function automatic int bank_of(int m, int al, int addr);
        int own;
        if (m == 0) own = (al == 0) ? 3 : (al == 1) ? 1 : (al == 2) ? 2 : 0;
        else        own = (al == 3) ? 3 : (al == 1) ? 2 : (al == 2) ? 1 : 0;
        if (own == 3) return (addr / BW) % 2;
        if (own == 1) return 0;
        if (own == 2) return 1;
        return -1;
    endfunction

    // One cycle: inputs set at negedge, result sampled at the following negedge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0; a_req = 1'b0; b_req = 1'b0; a_we = 1'b0; b_we = 1'b0;
    endtask

    task automatic set_alloc(input logic [7:0] v);
        cfg_we = 1'b1; cfg_wdata = v;
        step();
    endtask

    task automatic read_sweep(input int al, input bit first);
        for (int ad = 0; ad < WIN; ad++) begin
            a_req = 1'b1; a_addr = ad[WIN_AW-1:0];
            b_req = 1'b1; b_addr = ad[WIN_AW-1:0];
            step();
            for (int m = 0; m < 2; m++) begin
                int bk = bank_of(m, al, ad);
                logic [DATA_W-1:0] act = (m == 0) ? a_rdata : b_rdata;
                if (bk < 0) check("R7 unowned read zero", act, '0);
                else if (valid[bk][ad % BW])
                    check(first ? "R2 handover keeps data" : "R5/R6 mirror map",
                          act, model[bk][ad % BW]);
            end
        end
    endtask

    task automatic write_sweep(input int al);
        for (int ad = 0; ad < WIN; ad++) begin
            logic [DATA_W-1:0] da = DATA_W'((al << 12) | (0 << 11) | ad);
            logic [DATA_W-1:0] db = DATA_W'((al << 12) | (1 << 11) | ad);
            int ba = bank_of(0, al, ad);
            int bb = bank_of(1, al, ad);
            a_req = 1'b1; a_we = 1'b1; a_addr = ad[WIN_AW-1:0]; a_wdata = da;
            b_req = 1'b1; b_we = 1'b1; b_addr = ad[WIN_AW-1:0]; b_wdata = db;
            if (ba >= 0) begin model[ba][ad % BW] = da; valid[ba][ad % BW] = 1'b1; end
            if (bb >= 0) begin model[bb][ad % BW] = db; valid[bb][ad % BW] = 1'b1; end
            step();
        end
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int b = 0; b < 2; b++) for (int w = 0; w < BW; w++) valid[b][w] = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset alloc", {14'd0, alloc_o}, 16'd0);
        check("R1 reset a_rdata", a_rdata, '0);
        check("R1 reset b_rdata", b_rdata, '0);

        for (int al = 0; al < 4; al++) begin
            set_alloc(8'(al));
            check("R9 status shows alloc", {14'd0, alloc_o}, 16'(al));
            read_sweep(al, 1'b1);
            write_sweep(al);
            read_sweep(al, 1'b0);
        end

        // R4: upper bits ignored; 0xFD -> allocation 1
        set_alloc(8'hFD);
        check("R4 upper cfg bits ignored", {14'd0, alloc_o}, 16'd1);

        // R4: access in the write cycle uses old mapping (alloc 1: A owns bank 0)
        a_req = 1'b1; a_addr = 8'h03;
        cfg_we = 1'b1; cfg_wdata = 8'h03;
        step();
        check("R4 old mapping in write cycle", a_rdata, model[0][3]);
        check("R4 new alloc after edge", {14'd0, alloc_o}, 16'd3);
        a_req = 1'b1; a_addr = 8'h03;
        step();
        check("R4 new mapping next cycle", a_rdata, '0);

        // R7: A writes while owning nothing, then regains bank 0 and reads it back
        a_req = 1'b1; a_we = 1'b1; a_addr = 8'h05; a_wdata = 16'hBEEF;
        step();
        set_alloc(8'h01);
        a_req = 1'b1; a_addr = 8'h05;
        step();
        check("R7 dropped write left bank", a_rdata, model[0][5]);

        // R8: idle cycle after a read returns zero
        step();
        check("R8 idle read data zero", a_rdata, '0);
        check("R8 idle read data zero B", b_rdata, '0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule